// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a memory bus that moves one 32-bit word per transaction. It keeps 64 lines of four words each. A byte address is cut into three fields. Bits 3:0 are the offset within a line, and bits 3:2 of that offset pick the word. Bits 9:4 pick the line. Bits 31:10 are the tag stored beside the line. A request whose line is valid and whose tag matches is served in the cycle it is presented. Reads return the word at once. Writes merge the enabled bytes into the line and mark it dirty, without touching memory.

On a miss, the processor port is held off. If the resident line is dirty, its four words are first written to memory at the victim's own address, lowest word first. The controller then fetches the four words of the requested line, also lowest first, and installs the new tag. Finally it completes the access in a response cycle. A write miss therefore fetches the line and merges into it. Only one request is in flight at a time.

Top module: `lcache_top`

## Requirements
- R1: The line is chosen by address bits 9:4 and the tag is bits 31:10. Two addresses that differ only above bit 9 compete for the same line. Addresses 1200 (line 11) and 1216 (line 12) can be resident together.
- R2: Reset clears every valid bit and every dirty bit, so the first access to any address after reset is a miss.
- R3: A request whose line is valid with a matching tag raises `cpuReady` in the same cycle as `cpuReq` and causes no memory transaction. A read returns the cached word.
- R4: A write hit updates only the cached word and causes no memory write. The line becomes dirty.
- R5: Replacing a dirty line first writes its four words to memory at the victim's line address. The word offsets go 0, 4, 8, 12 in that order, and all of these writes come before any fetch.
- R6: Replacing a clean or invalid line performs no memory write.
- R7: A miss fetches exactly four words at the requested line's base address plus 0, 4, 8 and 12, in that order, with `memWe` low.
- R8: A write miss fetches the whole line, merges the write into it, and leaves the other words equal to memory.
- R9: Bit i of `cpuBe` enables byte lane bits 8i+7:8i of the addressed word. Lanes whose bit is clear keep their prior value.
- R10: `cpuReady` stays low from the miss cycle until the response cycle. It is never high while `memReq` is high.
- R11: Once raised, `memReq`, `memAddr` and `memWe` hold steady until `memAck`. `memWe` is high only during write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Write data |
| cpuBe | input | 4 | Byte-lane enables for writes |
| cpuRdata | output | 32 | Read data, valid while `cpuReady` is high |
| cpuReady | output | 1 | Access completes at this clock edge |
| memReq | output | 1 | Memory word transaction request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | 32 | Word-aligned memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory transaction completes |

## Verification
The bench builds the cache with its default geometry: 64 lines of four 32-bit words and a 32-bit address. This puts the bit-10 alias close at hand, since addresses 0x100 and 0x500 both land on line 16. It also makes the worked example reachable, with address 1200 on line 11.

The bench's memory model answers each word after three wait cycles. Because of that, the stall window, the write-back-before-refill ordering and the request hold can each be observed across several cycles. Small addresses are enough to exercise clean eviction, dirty eviction, write-allocate with partial byte lanes, and the invalidation brought about by a second reset.

// File: rtl/lcache_pkg.sv
package lcache_pkg;

  // Control to datapath strobes, one bit per action
  typedef struct packed {
    logic latchReq;    // capture the presented request
    logic useLatched;  // datapath addresses from the captured request
    logic wbSel;       // memory address uses the stored (victim) tag
    logic fillWord;    // write memRdata into the line at the word counter
    logic lineDone;    // install tag, set valid, clear dirty
    logic cpuWrite;    // merge CPU write data into the addressed word
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } ctlState_t;

endpackage

// File: rtl/lcache_dpath.sv
module lcache_dpath
  import lcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 4,
  parameter int LINE_CNT   = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ADDR_W-1:0]                    cpuAddr,
  input  logic [8*WORD_BYTES-1:0]              cpuWdata,
  input  logic [WORD_BYTES-1:0]                cpuBe,
  input  logic                                 cpuWe,
  input  ctlStrobe_t                           strobe,
  input  logic [$clog2(LINE_WORDS)-1:0]        wordCnt,
  input  logic [8*WORD_BYTES-1:0]              memRdata,
  output logic                                 lineHit,
  output logic                                 victimDirty,
  output logic                                 reqWe,
  output logic [8*WORD_BYTES-1:0]              cpuRdata,
  output logic [ADDR_W-1:0]                    memAddr,
  output logic [8*WORD_BYTES-1:0]              memWdata
);

  localparam int DATA_W     = 8 * WORD_BYTES;
  localparam int BYTE_OFF_W = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = BYTE_OFF_W + WSEL_W;
  localparam int IDX_W      = $clog2(LINE_CNT);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;

  // Captured request
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     wdataQ;
  logic [WORD_BYTES-1:0] beQ;
  logic                  weQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      weQ    <= 1'b0;
    end else if (strobe.latchReq) begin
      addrQ  <= cpuAddr;
      wdataQ <= cpuWdata;
      beQ    <= cpuBe;
      weQ    <= cpuWe;
    end
  end

  assign reqWe = weQ;

  // Current access fields
  logic [ADDR_W-1:0]     curAddr;
  logic [DATA_W-1:0]     curWdata;
  logic [WORD_BYTES-1:0] curBe;
  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [WSEL_W-1:0]     wsel;

  assign curAddr  = strobe.useLatched ? addrQ  : cpuAddr;
  assign curWdata = strobe.useLatched ? wdataQ : cpuWdata;
  assign curBe    = strobe.useLatched ? beQ    : cpuBe;
  assign idx      = curAddr[OFF_W +: IDX_W];
  assign tag      = curAddr[OFF_W + IDX_W +: TAG_W];
  assign wsel     = curAddr[BYTE_OFF_W +: WSEL_W];

  // Line storage
  logic [LINE_CNT-1:0] validQ;
  logic [LINE_CNT-1:0] dirtyQ;
  logic [TAG_W-1:0]    tagQ  [LINE_CNT];
  logic [DATA_W-1:0]   dataQ [LINE_CNT][LINE_WORDS];

  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] mergedWord;

  assign rdWord      = dataQ[idx][wsel];
  assign lineHit     = validQ[idx] && (tagQ[idx] == tag);
  assign victimDirty = dirtyQ[idx];
  assign cpuRdata    = rdWord;
  assign memWdata    = dataQ[idx][wordCnt];
  assign memAddr     = {(strobe.wbSel ? tagQ[idx] : tag), idx, wordCnt,
                        {BYTE_OFF_W{1'b0}}};

  // Byte-lane merge
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign mergedWord[8*b +: 8] = curBe[b] ? curWdata[8*b +: 8] : rdWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWord) begin
      dataQ[idx][wordCnt] <= memRdata;
    end
    if (strobe.cpuWrite) begin
      dataQ[idx][wsel] <= mergedWord;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.lineDone) begin
      tagQ[idx] <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (strobe.lineDone) begin
        validQ[idx] <= 1'b1;
        dirtyQ[idx] <= 1'b0;
      end
      if (strobe.cpuWrite) begin
        dirtyQ[idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcache_ctrl.sv
module lcache_ctrl
  import lcache_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpuReq,
  input  logic                          cpuWe,
  input  logic                          lineHit,
  input  logic                          victimDirty,
  input  logic                          reqWe,
  input  logic                          memAck,
  output logic                          cpuReady,
  output logic                          memReq,
  output logic                          memWe,
  output ctlStrobe_t                    strobe,
  output logic [$clog2(LINE_WORDS)-1:0] wordCnt
);

  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  ctlState_t         state, stateNxt;
  logic [WSEL_W-1:0] cnt, cntNxt;
  logic              lastWord;

  assign lastWord = (cnt == LAST_WORD);
  assign wordCnt  = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobe   = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (lineHit) begin
            cpuReady        = 1'b1;
            strobe.cpuWrite = cpuWe;
          end else begin
            strobe.latchReq = 1'b1;
            cntNxt          = '0;
            stateNxt        = victimDirty ? ST_WRITEBACK : ST_REFILL;
          end
        end
      end
      ST_WRITEBACK: begin
        strobe.useLatched = 1'b1;
        strobe.wbSel      = 1'b1;
        memReq            = 1'b1;
        memWe             = 1'b1;
        if (memAck) begin
          cntNxt = cnt + WSEL_W'(1);
          if (lastWord) stateNxt = ST_REFILL;
        end
      end
      ST_REFILL: begin
        strobe.useLatched = 1'b1;
        memReq            = 1'b1;
        if (memAck) begin
          strobe.fillWord = 1'b1;
          cntNxt          = cnt + WSEL_W'(1);
          if (lastWord) begin
            strobe.lineDone = 1'b1;
            stateNxt        = ST_RESPOND;
          end
        end
      end
      ST_RESPOND: begin
        strobe.useLatched = 1'b1;
        strobe.cpuWrite   = reqWe;
        cpuReady          = 1'b1;
        stateNxt          = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lcache_top.sv
module lcache_top
  import lcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 4,
  parameter int LINE_CNT   = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [8*WORD_BYTES-1:0] cpuWdata,
  input  logic [WORD_BYTES-1:0]   cpuBe,
  output logic [8*WORD_BYTES-1:0] cpuRdata,
  output logic                    cpuReady,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [8*WORD_BYTES-1:0] memWdata,
  input  logic [8*WORD_BYTES-1:0] memRdata,
  input  logic                    memAck
);

  localparam int WSEL_W = $clog2(LINE_WORDS);

  ctlStrobe_t        strobe;
  logic [WSEL_W-1:0] wordCnt;
  logic              lineHit;
  logic              victimDirty;
  logic              reqWe;

  lcache_ctrl #(
    .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .lineHit    (lineHit),
    .victimDirty(victimDirty),
    .reqWe      (reqWe),
    .memAck     (memAck),
    .cpuReady   (cpuReady),
    .memReq     (memReq),
    .memWe      (memWe),
    .strobe     (strobe),
    .wordCnt    (wordCnt)
  );

  lcache_dpath #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .LINE_WORDS(LINE_WORDS),
    .LINE_CNT  (LINE_CNT)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cpuBe      (cpuBe),
    .cpuWe      (cpuWe),
    .strobe     (strobe),
    .wordCnt    (wordCnt),
    .memRdata   (memRdata),
    .lineHit    (lineHit),
    .victimDirty(victimDirty),
    .reqWe      (reqWe),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/lcache_chk.sv
module lcache_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 4,
  parameter int LINE_CNT   = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpuReq,
  input logic                    cpuWe,
  input logic [ADDR_W-1:0]       cpuAddr,
  input logic [8*WORD_BYTES-1:0] cpuWdata,
  input logic [WORD_BYTES-1:0]   cpuBe,
  input logic [8*WORD_BYTES-1:0] cpuRdata,
  input logic                    cpuReady,
  input logic                    memReq,
  input logic                    memWe,
  input logic [ADDR_W-1:0]       memAddr,
  input logic [8*WORD_BYTES-1:0] memWdata,
  input logic [8*WORD_BYTES-1:0] memRdata,
  input logic                    memAck
);

  localparam int BYTE_OFF_W = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  logic [WSEL_W-1:0] memWord;
  assign memWord = memAddr[BYTE_OFF_W +: WSEL_W];

  // R11
  memreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);

  // R11
  memwe_qual_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memReq);

  // R7
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> memAddr[BYTE_OFF_W-1:0] == '0);

  // R5
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    memReq && memWe && memAck && memWord == LAST_WORD |=> memReq && !memWe);

  // R7
  fill_continues_chk: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe && memAck && memWord != LAST_WORD |=> memReq && !memWe);

endmodule

bind lcache_top lcache_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_BYTES(WORD_BYTES),
  .LINE_WORDS(LINE_WORDS),
  .LINE_CNT  (LINE_CNT)
) u_chk (.*);

// File: tb/test_lcache_top.sv
`timescale 1ns/1ps
module test_lcache_top;

  localparam int  MEM_LAT = 3;
  localparam real HALF    = 2.5;  // 200 MHz

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [3:0]  expRd;
    logic [3:0]  expWr;
    logic [31:0] vicBase;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_0100, 32'h0,          4'h0, 4'd4, 4'd0, 32'h0},        // 0 cold miss
    '{1'b0, 32'h0000_0104, 32'h0,          4'h0, 4'd0, 4'd0, 32'h0},        // 1 read hit
    '{1'b1, 32'h0000_0108, 32'hAABB_CCDD, 4'hF, 4'd0, 4'd0, 32'h0},        // 2 write hit
    '{1'b0, 32'h0000_0108, 32'h0,          4'h0, 4'd0, 4'd0, 32'h0},        // 3 read back
    '{1'b0, 32'h0000_0500, 32'h0,          4'h0, 4'd4, 4'd4, 32'h0000_0100}, // 4 dirty evict
    '{1'b0, 32'h0000_0100, 32'h0,          4'h0, 4'd4, 4'd0, 32'h0},        // 5 clean evict
    '{1'b1, 32'h0000_2004, 32'h1234_5678, 4'h3, 4'd4, 4'd0, 32'h0},        // 6 write miss
    '{1'b0, 32'h0000_2000, 32'h0,          4'h0, 4'd0, 4'd0, 32'h0},        // 7 fetched word
    '{1'b0, 32'h0000_2004, 32'h0,          4'h0, 4'd0, 4'd0, 32'h0},        // 8 merged word
    '{1'b1, 32'h0000_04B0, 32'hCAFE_F00D, 4'hF, 4'd4, 4'd0, 32'h0},        // 9 line 11
    '{1'b0, 32'h0000_04C0, 32'h0,          4'h0, 4'd4, 4'd0, 32'h0},        // 10 line 12
    '{1'b0, 32'h0000_04B0, 32'h0,          4'h0, 4'd0, 4'd0, 32'h0},        // 11 still resident
    '{1'b0, 32'h0000_08B0, 32'h0,          4'h0, 4'd4, 4'd4, 32'h0000_04B0}  // 12 alias of 11
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cpuReq;
  logic        cpuWe;
  logic [31:0] cpuAddr;
  logic [31:0] cpuWdata;
  logic [3:0]  cpuBe;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        memAck;

  int nChecks = 0;
  int nFail   = 0;

  always #(HALF) clk = ~clk;

  lcache_top i_lcache_top (
    .clk(clk), .rst(rst),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuBe(cpuBe), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  // Memory image and expected (program-visible) image
  logic [31:0] memArr [logic [31:0]];
  logic [31:0] refArr [logic [31:0]];

  function automatic logic [31:0] initWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] memRead(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : initWord(a);
  endfunction

  function automatic logic [31:0] refRead(input logic [31:0] a);
    return refArr.exists(a) ? refArr[a] : initWord(a);
  endfunction

  // Wait-state memory with an operation log
  int          waitCnt;
  int          nOps = 0;
  logic [31:0] opAddr [64];
  logic        opWe   [64];

  always @(posedge clk) begin
    if (rst) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt == MEM_LAT) begin
          memAck  <= 1'b1;
          waitCnt <= 0;
          if (memWe) memArr[memAddr] = memWdata;
          else       memRdata <= memRead(memAddr);
          opAddr[nOps % 64] = memAddr;
          opWe[nOps % 64]   = memWe;
          nOps = nOps + 1;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic we, input logic [31:0] addr,
                          input logic [31:0] wdata, input logic [3:0] be,
                          output logic [31:0] rd, output int lat, output int base);
    logic [31:0] wa;
    logic [31:0] old;
    base = nOps;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata; cpuBe = be;
    lat = 0;
    #1;
    while (!cpuReady && lat < 2000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rd = cpuRdata;
    @(posedge clk);
    #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
    if (we) begin
      wa  = {addr[31:2], 2'b00};
      old = refRead(wa);
      for (int b = 0; b < 4; b++) if (be[b]) old[8*b +: 8] = wdata[8*b +: 8];
      refArr[wa] = old;
    end
  endtask

  initial begin
    #(2.0 * HALF * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          lat;
    int          base;
    int          ops;
    logic [31:0] lineBase;
    logic [31:0] expMerged;

    rst = 1'b1; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0; cpuBe = '0;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state at the ports
    check(cpuReady == 1'b0, "R2 ready in reset", 32'(cpuReady), 32'h0);
    check(memReq == 1'b0, "R2 memReq in reset", 32'(memReq), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      doAccess(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd, lat, base);
      ops = nOps - base;
      lineBase = {VECS[i].addr[31:4], 4'h0};
      check(lat < 2000, "R10 access completes", 32'(lat), 32'd0);
      if (VECS[i].expRd == 0) begin
        // R3: hit answered in the request cycle, no memory traffic
        check(lat == 0, "R3 hit latency", 32'(lat), 32'd0);
      end else begin
        // R10: stalled for a miss
        check(lat > 0, "R10 miss stalls", 32'(lat), 32'd1);
      end
      if (VECS[i].expWr != 0)
        check(ops == VECS[i].expRd + VECS[i].expWr, "R5 op count", 32'(ops),
              32'(VECS[i].expRd + VECS[i].expWr));
      else
        check(ops == VECS[i].expRd, "R6 op count, no write-back", 32'(ops),
              32'(VECS[i].expRd));
      for (int k = 0; k < VECS[i].expWr; k++) begin
        check(opWe[(base + k) % 64] == 1'b1 &&
              opAddr[(base + k) % 64] == VECS[i].vicBase + 32'(4 * k),
              "R5 write-back order", opAddr[(base + k) % 64], VECS[i].vicBase + 32'(4 * k));
      end
      for (int k = 0; k < VECS[i].expRd; k++) begin
        int j;
        j = (base + VECS[i].expWr + k) % 64;
        check(opWe[j] == 1'b0 && opAddr[j] == lineBase + 32'(4 * k),
              "R7 refill order", opAddr[j], lineBase + 32'(4 * k));
      end
      if (!VECS[i].we)
        check(rd == refRead({VECS[i].addr[31:2], 2'b00}), "R3 read data", rd,
              refRead({VECS[i].addr[31:2], 2'b00}));

      if (i == 3) begin
        // R4: write hit left memory untouched
        check(memRead(32'h108) == initWord(32'h108), "R4 memory unchanged",
              memRead(32'h108), initWord(32'h108));
      end
      if (i == 4) begin
        // R5: dirty data reached memory
        check(memRead(32'h108) == 32'hAABB_CCDD, "R5 written back word",
              memRead(32'h108), 32'hAABB_CCDD);
      end
      if (i == 7) begin
        // R8: other words of an allocated line come from memory
        check(rd == initWord(32'h2000), "R8 fetched word", rd, initWord(32'h2000));
      end
      if (i == 8) begin
        // R9: only lanes 1:0 replaced
        expMerged = {initWord(32'h2004)[31:16], 16'h5678};
        check(rd == expMerged, "R9 byte-lane merge", rd, expMerged);
      end
      if (i == 12) begin
        // R1: 0x8B0 shares line 11 with 1200, which was evicted
        check(memRead(32'h4B0) == 32'hCAFE_F00D, "R1 alias evicts line 11",
              memRead(32'h4B0), 32'hCAFE_F00D);
      end
    end

    // R2: a second reset invalidates resident lines
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    doAccess(1'b0, 32'h0000_0104, 32'h0, 4'h0, rd, lat, base);
    ops = nOps - base;
    check(ops == 4, "R2 miss after reset", 32'(ops), 32'd4);
    check(rd == refRead(32'h104), "R2 data after reset", rd, refRead(32'h104));

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule